// File: doc/BRIEF.md
# Register Busy-Bit Interlock

This unit guards the decode stage of an in-order pipeline that has no result forwarding. It keeps one busy flag for each architectural register. When decode issues an instruction that will write a register, the flag for that register goes up. When the instruction later writes its result back, the flag comes down. While an instruction in decode names a source register whose flag is up, the unit raises a stall. Decode then holds that instruction, and every instruction behind it waits too, because issue is in order.

Each source operand arrives as an index with a valid flag. The surrounding decoder sets these flags as follows:
- A three-register form presents both the base and the second operand as valid.
- An immediate form presents only the base as valid.
- A single-operand form presents only the second operand as valid.
- An instruction with no destination, such as a no-op or a halt, presents its destination as not valid.

Register 0 reads as the constant zero. It is therefore never tracked, and naming it never causes a stall. This also covers an address-load that uses r0 as its base.

The busy vector is an output so that the pipeline can be traced. A cleared flag becomes visible one edge after writeback. As a result, a consumer issues in the cycle after its producer's writeback cycle, never in the writeback cycle itself.

Top module: `reg_busy_tracker`

## Requirements
- R1: While `rst` is high at a rising edge, all bits of `busy_vec` are cleared, so after reset `busy_vec` is 0 and `stall` is 0 for any sources.
- R2: When `dec_go` is 1, `stall` is 0, `dst_vld` is 1 and `dst_idx` is nonzero at a rising edge, bit `dst_idx` of `busy_vec` is 1 after that edge.
- R3: When `wb_en` is 1 at a rising edge and no issue targets the same register, bit `wb_idx` of `busy_vec` is 0 after that edge.
- R4: `stall` is 1 in the same cycle that any source slot s with `src_vld[s]`=1 names a nonzero register whose bit in `busy_vec` is 1. Slot s occupies bits `src_idx[s*AW +: AW]`, with slot 0 the base operand and slot 1 the second operand.
- R5: A source slot whose `src_vld` bit is 0 never causes `stall`, whatever index it carries.
- R6: Bit 0 of `busy_vec` is never set, and register 0 as a valid source never causes `stall`.
- R7: With `dst_vld` 0, an issue sets no bit of `busy_vec`. This is how no-op and halt instructions behave.
- R8: While `stall` is 1, `dec_go` sets no busy bit, so a held instruction and everything behind it do not issue.
- R9: If an issue and a writeback name the same register at the same edge, that register's bit is 1 after the edge.
- R10: In the cycle whose edge writes back a source's producer, `stall` is still 1. In the following cycle the source no longer stalls and the consumer can issue.
- R11: With `dec_go` 0, no busy bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| src_idx | input | NUM_SRC*AW | Packed source register indices, slot 0 in the low bits |
| src_vld | input | NUM_SRC | Per-slot flag that the source is actually read |
| dst_idx | input | AW | Destination register of the instruction in decode |
| dst_vld | input | 1 | Instruction in decode writes a register |
| dec_go | input | 1 | Decode attempts to issue this cycle |
| wb_idx | input | AW | Register being written back |
| wb_en | input | 1 | A writeback happens this cycle |
| stall | output | 1 | Decode must hold its instruction |
| busy_vec | output | NUM_REGS | Busy flag per register, bit n for register n |

## Verification
The signal `stall` is combinational from the current busy flags and the source fields. It is due in the same cycle as its stimulus. The bench drives inputs on the falling edge and compares `stall` one nanosecond later.

A set or clear of a busy flag is due one rising edge after the issue or writeback that causes it. The bench updates its own model at that edge and compares `busy_vec` at the next falling edge, before it drives anything new.

An exhaustive sweep covers every busy pattern of an 8-register file against every pair of source indices and valid flags. Directed sequences then cover the writeback-cycle stall, a simultaneous set and clear, and issue attempts that are blocked or that have no destination.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // One-hot register mask; register 0 is never tracked, so it yields zero.
  function automatic logic [31:0] reg_mask(input logic [4:0] idx, input logic en);
    logic [31:0] m;
    m = '0;
    if (en && idx != 5'd0) m[idx] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/sb_hazard.sv
module sb_hazard import sb_pkg::*; #(
  parameter int NUM_REGS = 8,
  parameter int NUM_SRC  = 2,
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_REGS-1:0]    busy,
  input  logic [NUM_SRC*AW-1:0]  src_idx,
  input  logic [NUM_SRC-1:0]     src_vld,
  output logic [NUM_SRC-1:0]     src_hit,
  output logic                   stall
);
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [NUM_REGS-1:0] want;
    assign want       = NUM_REGS'(reg_mask(5'(src_idx[s*AW +: AW]), src_vld[s]));
    assign src_hit[s] = |(want & busy);
  end

  assign stall = |src_hit;

  // R5: sources marked not read cannot hold decode
  assert_invalid_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (src_vld == '0) |-> !stall);
endmodule

// File: rtl/sb_busy_array.sv
module sb_busy_array #(
  parameter int NUM_REGS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_REGS-1:0] set_mask,
  input  logic [NUM_REGS-1:0] clr_mask,
  output logic [NUM_REGS-1:0] busy
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)              busy[g] <= 1'b0;
      else if (set_mask[g]) busy[g] <= 1'b1;
      else if (clr_mask[g]) busy[g] <= 1'b0;
    end

    // R2 and R9: an issue marks its destination even against a same-edge writeback
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
      set_mask[g] |=> busy[g]);
    // R3: writeback releases the register
    assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
      (clr_mask[g] && !set_mask[g]) |=> !busy[g]);
  end
endmodule

// File: rtl/reg_busy_tracker.sv
module reg_busy_tracker import sb_pkg::*; #(
  parameter int NUM_REGS = 8,
  parameter int NUM_SRC  = 2,
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_SRC*AW-1:0] src_idx,
  input  logic [NUM_SRC-1:0]    src_vld,
  input  logic [AW-1:0]         dst_idx,
  input  logic                  dst_vld,
  input  logic                  dec_go,
  input  logic [AW-1:0]         wb_idx,
  input  logic                  wb_en,
  output logic                  stall,
  output logic [NUM_REGS-1:0]   busy_vec
);
  logic [NUM_SRC-1:0]  src_hit;
  logic                issue;
  logic [NUM_REGS-1:0] set_mask;
  logic [NUM_REGS-1:0] clr_mask;

  sb_hazard #(.NUM_REGS(NUM_REGS), .NUM_SRC(NUM_SRC)) u_hazard (
    .clk(clk), .rst(rst), .busy(busy_vec), .src_idx(src_idx),
    .src_vld(src_vld), .src_hit(src_hit), .stall(stall));

  assign issue    = dec_go & ~stall;
  assign set_mask = NUM_REGS'(reg_mask(5'(dst_idx), issue & dst_vld));
  assign clr_mask = NUM_REGS'(reg_mask(5'(wb_idx), wb_en));

  sb_busy_array #(.NUM_REGS(NUM_REGS)) u_busy (
    .clk(clk), .rst(rst), .set_mask(set_mask), .clr_mask(clr_mask), .busy(busy_vec));

  // R6: register 0 is never marked
  assert_r0_free_R6: assert property (@(posedge clk) disable iff (rst) !busy_vec[0]);
  // R8: a held instruction marks nothing
  assert_hold_no_set_R8: assert property (@(posedge clk) disable iff (rst)
    (stall && !wb_en) |=> busy_vec == $past(busy_vec));
  // R7: no destination, no mark
  assert_nodst_R7: assert property (@(posedge clk) disable iff (rst)
    (!dst_vld && !wb_en) |=> busy_vec == $past(busy_vec));
  // R11: no issue attempt, no mark
  assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (!dec_go && !wb_en) |=> busy_vec == $past(busy_vec));
endmodule

// File: tb/test_reg_busy_tracker.sv
`timescale 1ns/1ps
module test_reg_busy_tracker;
  localparam int NR = 8;
  localparam int AW = 3;
  localparam int NS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [NS*AW-1:0] src_idx = '0;
  logic [NS-1:0]    src_vld = '0;
  logic [AW-1:0]    dst_idx = '0, wb_idx = '0;
  logic             dst_vld = 1'b0, dec_go = 1'b0, wb_en = 1'b0;
  logic             stall;
  logic [NR-1:0]    busy_vec;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [NR-1:0] model = '0;

  reg_busy_tracker #(.NUM_REGS(NR), .NUM_SRC(NS)) i_reg_busy_tracker (
    .clk(clk), .rst(rst), .src_idx(src_idx), .src_vld(src_vld),
    .dst_idx(dst_idx), .dst_vld(dst_vld), .dec_go(dec_go),
    .wb_idx(wb_idx), .wb_en(wb_en), .stall(stall), .busy_vec(busy_vec));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit ref_stall(input logic [2:0] a, input bit va,
                                   input logic [2:0] b, input bit vb);
    bit s = 0;
    if (va && a != 0 && model[a]) s = 1;
    if (vb && b != 0 && model[b]) s = 1;
    return s;
  endfunction

  // One cycle: drive at falling edge, check stall, then busy at the next falling edge.
  task automatic step(input logic [2:0] a, input bit va, input logic [2:0] b, input bit vb,
                      input logic [2:0] d, input bit dv, input bit go,
                      input logic [2:0] w, input bit we, input string req);
    bit e;
    logic [NR-1:0] nxt;
    src_idx = {b, a}; src_vld = {vb, va};
    dst_idx = d; dst_vld = dv; dec_go = go; wb_idx = w; wb_en = we;
    #1;
    e = ref_stall(a, va, b, vb);
    chk(stall === e, req, int'(stall), int'(e));
    nxt = model;
    if (we) nxt[w] = 1'b0;
    if (go && !e && dv && d != 0) nxt[d] = 1'b1;
    @(posedge clk);
    model = nxt;
    @(negedge clk);
    chk(busy_vec === model, req, int'(busy_vec), int'(model));
    dec_go = 1'b0; wb_en = 1'b0; dst_vld = 1'b0; src_vld = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model = '0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: cleared state, every register probed as a source
    chk(busy_vec === '0, "R1", int'(busy_vec), 0);
    for (int r = 0; r < NR; r++) begin
      src_idx = {3'(r), 3'(r)}; src_vld = 2'b11; #1;
      chk(stall === 1'b0, "R1", int'(stall), 0);
    end
    src_vld = '0;

    // Exhaustive sweep: every busy pattern against every source pair (R2, R4, R5, R6)
    for (int p = 0; p < (1 << NR); p++) begin
      do_reset();
      for (int r = 0; r < NR; r++)
        if (p[r]) step(0, 0, 0, 0, 3'(r), 1, 1, 0, 0, (r == 0) ? "R6" : "R2");
      for (int a = 0; a < NR; a++)
        for (int b = 0; b < NR; b++)
          for (int v = 0; v < 4; v++)
            step(3'(a), v[0], 3'(b), v[1], 0, 0, 0, 0, 0, (v == 0) ? "R5" : "R4");
    end

    // R7: issue with no destination
    do_reset();
    step(0, 0, 0, 0, 3'd5, 0, 1, 0, 0, "R7");
    // R11: destination valid but no issue attempt
    step(0, 0, 0, 0, 3'd5, 1, 0, 0, 0, "R11");
    // R8: held instruction does not mark its destination
    step(0, 0, 0, 0, 3'd2, 1, 1, 0, 0, "R2");
    step(3'd2, 1, 0, 0, 3'd6, 1, 1, 0, 0, "R8");
    chk(busy_vec[6] === 1'b0, "R8", int'(busy_vec[6]), 0);
    // R10: writeback cycle still stalls, next cycle issues
    step(3'd2, 1, 0, 0, 3'd6, 1, 1, 3'd2, 1, "R10");
    chk(busy_vec[6] === 1'b0, "R10", int'(busy_vec[6]), 0);
    step(3'd2, 1, 0, 0, 3'd6, 1, 1, 0, 0, "R10");
    chk(busy_vec[6] === 1'b1, "R10", int'(busy_vec[6]), 1);
    // R9: same-edge set and clear of one register
    step(0, 0, 0, 0, 3'd3, 1, 1, 0, 0, "R2");
    step(0, 0, 0, 0, 3'd3, 1, 1, 3'd3, 1, "R9");
    chk(busy_vec[3] === 1'b1, "R9", int'(busy_vec[3]), 1);
    // R3: plain writeback clears
    step(0, 0, 0, 0, 0, 0, 0, 3'd3, 1, "R3");
    chk(busy_vec[3] === 1'b0, "R3", int'(busy_vec[3]), 0);
    step(0, 0, 3'd6, 1, 0, 0, 0, 3'd6, 1, "R3");
    // R6: r0 destination with writeback elsewhere
    step(0, 1, 0, 1, 0, 1, 1, 3'd1, 1, "R6");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule